// File: doc/BRIEF.md
# Annunciator and Double-Hires Switch Unit

This unit sits on the I/O page of an 8-bit computer and turns bus accesses at a handful of fixed addresses into four latched annunciator outputs. Eight consecutive addresses starting at C058 drive the four bits. The even address of each pair clears its bit and the odd address sets it. Whether the access is a read or a write does not matter.

Annunciator 3 also controls a double-resolution graphics mode. When that annunciator is low, the mode enable is high.

A separate location at C07F does two jobs. A read of it returns the mode enable in bit 7. Any access to it, read or write, fires a one-clock start pulse towards the paddle timers. The timers and the video logic live elsewhere.

Top module: `ann_switch_unit`

## Requirements
- R1: While rst_n is low at a clock edge, all four annunciator bits become 1, dhr_en becomes 0 and pdl_trig becomes 0, even if a valid access is presented in the same cycle.
- R2: A valid access, read or write, to C058, C05A, C05C or C05E clears annunciator bit 0, 1, 2 or 3 respectively, visible from the cycle after the access.
- R3: A valid access, read or write, to C059, C05B, C05D or C05F sets annunciator bit 0, 1, 2 or 3 respectively, visible from the cycle after the access.
- R4: dhr_en is 1 exactly when annunciator bit 3 is 0. It changes in the same cycle as that bit.
- R5: During a valid read of C07F, rdata is 0x80 if dhr_en is 1 and 0x00 if it is 0. rdata is combinational, in the cycle of the access.
- R6: A valid access to C07F, read or write, makes pdl_trig high for exactly the one cycle that follows that access.
- R7: A write to C07F changes neither the annunciator bits nor dhr_en.
- R8: When acc_vld is low, no address or wr value changes any output state, and pdl_trig stays low.
- R9: rdata is 0x00 in every cycle that is not a valid read of C07F. This includes reads of C058 to C05F.
- R10: Accesses to addresses other than C07F never raise pdl_trig.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Bus address |
| wr | input | 1 | 1 = write, 0 = read |
| acc_vld | input | 1 | Access qualifier for this cycle |
| annun | output | 4 | Annunciator bits, bit i = annunciator i |
| dhr_en | output | 1 | Double-resolution graphics enable |
| pdl_trig | output | 1 | One-cycle paddle-timer start pulse |
| rdata | output | 8 | Read data for the status location |

## Verification
The status read and the timer trigger come from the same C07F read. That read reports the mode enable on rdata in the access cycle. The pulse appears in the following cycle.

The bench provokes the overlap by reading C07F in the access right after a clear or set of annunciator 3. In that case the returned byte must already reflect the new mode, and the pulse must follow one cycle later.

A second case issues two back-to-back C07F accesses. It judges that pdl_trig stays high for two cycles and then drops.

// File: rtl/ann_pkg.sv
// Package: shared constants and the decoded-hit record for the annunciator unit.
// Assumes a 16-bit address bus and an 8-bit data bus by default.
package ann_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 8;
    localparam int NUM_ANN    = 4;

    // One decoded access: per-bit clear/set strobes, trigger hit, status read.
    typedef struct packed {
        logic [NUM_ANN-1:0] clr;
        logic [NUM_ANN-1:0] set;
        logic               trig;
        logic               stat_rd;
    } ann_hits_t;
endpackage

// File: rtl/ann_decode.sv
// Module: ann_decode
// Turns a qualified bus access into one-hot clear/set strobes per annunciator,
// a trigger hit for the status location and a status-read flag.
// Assumes annunciator pairs are consecutive from ANN_BASE, even = clear, odd = set.
module ann_decode
    import ann_pkg::*;
#(
    parameter int                ADDR_W    = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] ANN_BASE  = 16'hC058,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hC07F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              acc_vld,
    output ann_hits_t         hits
);
    logic [NUM_ANN-1:0] clr_v;
    logic [NUM_ANN-1:0] set_v;

    for (genvar i = 0; i < NUM_ANN; i++) begin : g_pair
        localparam logic [ADDR_W-1:0] CLR_A = ANN_BASE + ADDR_W'(2 * i);
        localparam logic [ADDR_W-1:0] SET_A = ANN_BASE + ADDR_W'(2 * i + 1);
        // Per-annunciator address match, direction ignored.
        assign clr_v[i] = acc_vld && (addr == CLR_A);
        assign set_v[i] = acc_vld && (addr == SET_A);
    end

    // Assemble the hit record.
    always_comb begin
        hits.clr     = clr_v;
        hits.set     = set_v;
        hits.trig    = acc_vld && (addr == TRIG_ADDR);
        hits.stat_rd = acc_vld && !wr && (addr == TRIG_ADDR);
    end
endmodule

// File: rtl/ann_regs.sv
// Module: ann_regs
// Holds the annunciator bits, the double-resolution enable and the trigger pulse.
// Assumes clear and set of one bit never arrive together (distinct addresses).
module ann_regs
    import ann_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ANN-1:0] clr,
    input  logic [NUM_ANN-1:0] set,
    input  logic               trig_hit,
    output logic [NUM_ANN-1:0] annun,
    output logic               dhr_en,
    output logic               pdl_trig
);
    localparam int TOP = NUM_ANN - 1;

    // Update annunciators, mode enable and trigger pulse; reset sets all bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            annun    <= '1;
            dhr_en   <= 1'b0;
            pdl_trig <= 1'b0;
        end else begin
            annun    <= (annun & ~clr) | set;
            pdl_trig <= trig_hit;
            if (clr[TOP])
                dhr_en <= 1'b1;
            else if (set[TOP])
                dhr_en <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_ANN; i++) begin : g_chk
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !annun[i]); // R2
        AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> annun[i]); // R3
    end

    AST_DHR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        dhr_en == !annun[TOP]); // R4
    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> pdl_trig); // R6
    AST_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_hit |=> !pdl_trig); // R10
endmodule

// File: rtl/ann_rdata.sv
// Module: ann_rdata
// Drives the read-data byte: mode enable in the top bit on a status read, else zero.
// Assumes the status location is the only readable source in this unit.
module ann_rdata #(
    parameter int DATA_W = ann_pkg::DATA_W_DEF
) (
    input  logic              stat_rd,
    input  logic              dhr_en,
    output logic [DATA_W-1:0] rdata
);
    // Combinational read mux.
    always_comb begin
        rdata = '0;
        if (stat_rd)
            rdata[DATA_W-1] = dhr_en;
    end
endmodule

// File: rtl/ann_switch_unit.sv
// Module: ann_switch_unit (top)
// Annunciator soft-switch decode with double-resolution enable and paddle trigger.
// Assumes one access per cycle qualified by acc_vld; synchronous active-low reset.
module ann_switch_unit
    import ann_pkg::*;
#(
    parameter int                ADDR_W    = ADDR_W_DEF,
    parameter int                DATA_W    = DATA_W_DEF,
    parameter logic [ADDR_W-1:0] ANN_BASE  = 16'hC058,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hC07F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               acc_vld,
    output logic [NUM_ANN-1:0] annun,
    output logic               dhr_en,
    output logic               pdl_trig,
    output logic [DATA_W-1:0]  rdata
);
    ann_hits_t hits;

    ann_decode #(
        .ADDR_W    (ADDR_W),
        .ANN_BASE  (ANN_BASE),
        .TRIG_ADDR (TRIG_ADDR)
    ) u_dec (
        .addr    (addr),
        .wr      (wr),
        .acc_vld (acc_vld),
        .hits    (hits)
    );

    ann_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hits.clr),
        .set      (hits.set),
        .trig_hit (hits.trig),
        .annun    (annun),
        .dhr_en   (dhr_en),
        .pdl_trig (pdl_trig)
    );

    ann_rdata #(.DATA_W(DATA_W)) u_rd (
        .stat_rd (hits.stat_rd),
        .dhr_en  (dhr_en),
        .rdata   (rdata)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> ($stable(annun) && $stable(dhr_en) && !pdl_trig)); // R8
    AST_TRIG_WR_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && wr && addr == TRIG_ADDR) |=> ($stable(annun) && $stable(dhr_en))); // R7
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_vld && !wr && addr == TRIG_ADDR) |-> (rdata == '0)); // R9
endmodule

// File: tb/ann_switch_unit_test.sv
`timescale 1ns/100ps
module ann_switch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        wr = 1'b0;
    logic        acc_vld = 1'b0;
    logic [3:0]  annun;
    logic        dhr_en;
    logic        pdl_trig;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ann_switch_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .acc_vld(acc_vld),
        .annun(annun), .dhr_en(dhr_en), .pdl_trig(pdl_trig), .rdata(rdata)
    );

    // Vector: addr, wr, expected annun, dhr_en, pdl_trig (next cycle), rdata (same cycle)
    localparam int NV = 14;
    localparam logic [30:0] VEC [NV] = '{
        {16'hC058, 1'b0, 4'hE, 1'b0, 1'b0, 8'h00},
        {16'hC05A, 1'b1, 4'hC, 1'b0, 1'b0, 8'h00},
        {16'hC05C, 1'b0, 4'h8, 1'b0, 1'b0, 8'h00},
        {16'hC05E, 1'b1, 4'h0, 1'b1, 1'b0, 8'h00},
        {16'hC07F, 1'b0, 4'h0, 1'b1, 1'b1, 8'h80},
        {16'hC07F, 1'b1, 4'h0, 1'b1, 1'b1, 8'h00},
        {16'hC059, 1'b1, 4'h1, 1'b1, 1'b0, 8'h00},
        {16'hC05B, 1'b0, 4'h3, 1'b1, 1'b0, 8'h00},
        {16'hC05F, 1'b1, 4'hB, 1'b0, 1'b0, 8'h00},
        {16'hC07F, 1'b0, 4'hB, 1'b0, 1'b1, 8'h00},
        {16'hC05D, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00},
        {16'hC060, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00},
        {16'hC05E, 1'b1, 4'h7, 1'b1, 1'b0, 8'h00},
        {16'hC07F, 1'b0, 4'h7, 1'b1, 1'b1, 8'h80}
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // One access: drive at a falling edge, read rdata mid-cycle, judge state a cycle later.
    task automatic access(input logic [15:0] a, input logic w, input logic [7:0] exp_rd);
        @(negedge clk);
        addr = a; wr = w; acc_vld = 1'b1;
        #1 chk("R5/R9 rdata", int'(rdata), int'(exp_rd));
        @(negedge clk);
        acc_vld = 1'b0; wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 annun", int'(annun), 'hF);
        chk("R1 dhr_en", int'(dhr_en), 0);
        chk("R1 pdl_trig", int'(pdl_trig), 0);
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R5, R6, R7, R9, R10
        for (int k = 0; k < NV; k++) begin
            logic [30:0] v;
            v = VEC[k];
            access(v[30:15], v[14], v[7:0]);
            chk("R2/R3 annun", int'(annun), int'(v[13:10]));
            chk("R4 dhr_en", int'(dhr_en), int'(v[9]));
            chk("R6/R10 pdl_trig", int'(pdl_trig), int'(v[8]));
        end

        // R6: pulse is a single cycle
        @(negedge clk);
        chk("R6 pulse dropped", int'(pdl_trig), 0);

        // R8: no valid qualifier, no effect
        @(negedge clk);
        addr = 16'hC05F; wr = 1'b1; acc_vld = 1'b0;
        @(negedge clk);
        addr = 16'hC07F;
        @(negedge clk);
        chk("R8 annun", int'(annun), 'h7);
        chk("R8 pdl_trig", int'(pdl_trig), 0);
        chk("R9 rdata idle", int'(rdata), 0);

        // Same-cycle overlap: set AN3 then status-read C07F straight after
        @(negedge clk);
        addr = 16'hC05F; wr = 1'b0; acc_vld = 1'b1;
        @(negedge clk);
        addr = 16'hC07F;
        #1 chk("R5 rdata after AN3 set", int'(rdata), 0);
        chk("R4 dhr_en after set", int'(dhr_en), 0);
        @(negedge clk);
        #1 chk("R5 rdata second read", int'(rdata), 0);
        chk("R6 trig first", int'(pdl_trig), 1);
        @(negedge clk);
        acc_vld = 1'b0;
        chk("R6 trig second", int'(pdl_trig), 1);
        @(negedge clk);
        chk("R6 trig ends", int'(pdl_trig), 0);

        // R1: reset wins over a same-cycle clear of AN3
        addr = 16'hC05E; acc_vld = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        acc_vld = 1'b0; rst_n = 1'b1;
        chk("R1 annun under access", int'(annun), 'hF);
        chk("R1 dhr_en under access", int'(dhr_en), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule